// File: doc/BRIEF.md
# Peripheral Register Write-Lock Wrapper

This block sits between a memory-mapped request/response bus and one peripheral's register file. It guards a 16 KB window that is aligned to 16 KB. Every address it sees is an offset from the window base. Four areas are decoded from that offset:

- a normal area, where registers are read and written;
- a mirror alias, where a write both updates a register and locks the byte lanes it wrote;
- a lock area, with one lock byte for every 32-bit register word;
- a configuration word, which holds a sticky hard lock and a bar on user-mode access.

A design-time mask chooses which register words can be locked. The peripheral itself is outside the block. It sees a write strobe, a word index, data and byte enables, and it returns read data for the indexed word in the same cycle.

Requests use valid/ready. The bus accepts a request on a clock edge where both `req_valid` and `req_ready` are high. The response appears on the next cycle, with `rsp_valid` high and the read data and error flag beside it. The response stays unchanged while `rsp_ready` is low. While a response is waiting, no new request is accepted.

Top module: `reg_lock_guard`

## Requirements
- R1: Register words lie at offsets REG_BASE + 4*i, for i from 0 to NUM_REGS-1. An accepted read returns that word on the next cycle. An accepted write drives `per_we` for one cycle, with the word index and byte strobes. The response data of any write is 0.
- R2: A write to offset 0x2000 plus a register offset updates that register. In the same access it sets the lock bits of the lanes it strobed, provided the word is protectable.
- R3: Lock bytes start at offset 0x3800. A register at window offset X has its lock byte at 0x3800 + X/4, so the register at 0x200 has its lock byte at 0x3880. Within the lock byte, bits 3:0 lock byte lanes 3:0 of the register. Bits 7:4 are write enables: a lock bit changes only when its enable bit is 1 in the same write. The enable bits always read back as 0.
- R4: A write to a register (normal or mirror) that strobes any locked lane changes nothing and returns `rsp_err` = 1.
- R5: Reads of a locked register are always allowed and return its value with no error.
- R6: The configuration word is at offset 0x3FFC. Bit 31 is the hard lock, which is sticky until reset. Bit 30 forbids user-mode access. Both read back in place, and the other bits read as 0.
- R7: Once the hard lock is set, every lock bit and the configuration word are frozen. Writes to the lock area or to the configuration word then return `rsp_err` = 1 and have no effect. Mirror writes still update the register but no longer set any lock.
- R8: While bit 30 is set, any access with `req_user` = 1 returns `rsp_err` = 1 and read data 0, and changes nothing.
- R9: For words left out of PROT_MASK, the lock byte reads as 0 and writes to it have no effect. Such words are never write-blocked, including after mirror writes.
- R10: An offset that falls in none of the four areas returns `rsp_err` = 1 and data 0.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response data and error flag are held.
- R12: After reset: `rsp_valid` = 0, `req_ready` = 1, and the configuration word and all lock bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Request made in user mode |
| req_addr | input | 14 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte-lane enables of a write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access rejected or unmapped |
| per_we | output | 1 | Peripheral write strobe |
| per_idx | output | IDX_W | Peripheral word index, for both read and write |
| per_wdata | output | 32 | Peripheral write data |
| per_wstrb | output | 4 | Peripheral byte enables |
| per_rdata | input | 32 | Peripheral read data for `per_idx`, same cycle |

## Verification
The assertions assume that the request fields stay stable while `req_valid` is high and that the peripheral returns `per_rdata` combinationally for `per_idx`. The bench drives each request at a falling edge and removes it as soon as it has been accepted. It holds `rsp_ready` high except in one directed back-pressure case.

The random stimulus never sets bit 31 of the configuration word, so the hard lock cannot freeze the random phase. The hard lock is set only in the final directed sequence.

// File: rtl/rlk_pkg.sv
package rlk_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_REG,
    RG_MIR,
    RG_LOCK,
    RG_CFG
  } region_e;

  localparam int          WIN_AW    = 14;
  localparam logic [11:0] MIR_WORD  = 12'h800;
  localparam logic [11:0] LOCK_WORD = 12'hE00;
  localparam logic [11:0] CFG_WORD  = 12'hFFF;
endpackage

// File: rtl/rlk_decode.sv
module rlk_decode
  import rlk_pkg::*;
#(
  parameter int REG_BASE = 'h200,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic [WIN_AW-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx,
  output logic [11:0]       lock_word
);
  localparam logic [12:0] RB = 13'(REG_BASE >> 2);
  localparam logic [12:0] RE = 13'((REG_BASE >> 2) + NUM_REGS);

  logic [11:0] wa;
  logic [11:0] rel;
  logic        unused_lo;

  assign wa        = addr[WIN_AW-1:2];
  assign unused_lo = ^addr[1:0];
  assign lock_word = wa - LOCK_WORD;

  always_comb begin
    region = RG_NONE;
    idx    = '0;
    rel    = (wa >= MIR_WORD) ? (wa - MIR_WORD) : wa;
    if (wa == CFG_WORD) begin
      region = RG_CFG;
    end else if (wa >= LOCK_WORD) begin
      region = RG_LOCK;
    end else if ({1'b0, rel} >= RB && {1'b0, rel} < RE) begin
      region = (wa >= MIR_WORD) ? RG_MIR : RG_REG;
      idx    = IDX_W'({1'b0, rel} - RB);
    end
  end
endmodule

// File: rtl/rlk_lockbank.sv
module rlk_lockbank #(
  parameter int                  REG_BASE  = 'h200,
  parameter int                  NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0] PROT_MASK = '1,
  parameter int                  IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frozen,
  input  logic             wr_en,
  input  logic [11:0]      wr_word,
  input  logic [31:0]      wdata,
  input  logic [3:0]       wstrb,
  input  logic             mir_set,
  input  logic [IDX_W-1:0] mir_idx,
  input  logic [3:0]       mir_lanes,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [3:0]       cur_lock,
  output logic [31:0]      rd_data
);
  localparam int RBW = REG_BASE >> 2;

  logic [4*NUM_REGS-1:0] lk_all;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    localparam int LW = (RBW + i) >> 2;
    localparam int LN = (RBW + i) & 3;
    if (PROT_MASK[i]) begin : g_prot
      logic [3:0] lk_q;
      logic [3:0] lk_d;
      always_comb begin
        lk_d = lk_q;
        if (wr_en && wr_word == 12'(LW) && wstrb[LN]) begin
          for (int j = 0; j < 4; j++) begin
            if (wdata[8*LN+4+j]) lk_d[j] = wdata[8*LN+j];
          end
        end
        if (mir_set && mir_idx == IDX_W'(i)) lk_d = lk_d | mir_lanes;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lk_q <= '0;
        else if (!frozen) lk_q <= lk_d;
      end
      assign lk_all[4*i +: 4] = lk_q;
    end else begin : g_open
      assign lk_all[4*i +: 4] = 4'b0000;
    end
  end

  always_comb begin
    cur_lock = '0;
    rd_data  = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) cur_lock = lk_all[4*i +: 4];
      if (wr_word == 12'((RBW + i) >> 2)) rd_data[8*((RBW + i) & 3) +: 4] = lk_all[4*i +: 4];
    end
  end

  p_frozen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(lk_all));
endmodule

// File: rtl/rlk_cfg.sv
module rlk_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] wbits,
  output logic       hard,
  output logic       ufb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard <= 1'b0;
      ufb  <= 1'b0;
    end else if (we && !hard) begin
      hard <= wbits[1];
      ufb  <= wbits[0];
    end
  end

  p_hard_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hard |=> hard);
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hard |=> $stable(ufb));
endmodule

// File: rtl/reg_lock_guard.sv
module reg_lock_guard
  import rlk_pkg::*;
#(
  parameter int                  REG_BASE  = 'h200,
  parameter int                  NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0] PROT_MASK = 8'b1011_0111,
  parameter int                  IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [13:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_wstrb,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              per_we,
  output logic [IDX_W-1:0]  per_idx,
  output logic [31:0]       per_wdata,
  output logic [3:0]        per_wstrb,
  input  logic [31:0]       per_rdata
);
  region_e     region;
  logic [11:0] lock_word;
  logic [3:0]  cur_lock;
  logic [31:0] lock_rd;
  logic        hard, ufb;
  logic        acc, blk_user, wr_hit, lane_clash, frozen_hit;
  logic        mir_set, lk_we, cfg_we;
  logic        err_c;
  logic [31:0] rd_c;

  rlk_decode #(.REG_BASE(REG_BASE), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .region(region), .idx(per_idx), .lock_word(lock_word)
  );

  rlk_lockbank #(
    .REG_BASE(REG_BASE), .NUM_REGS(NUM_REGS), .PROT_MASK(PROT_MASK), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .frozen(hard),
    .wr_en(lk_we), .wr_word(lock_word), .wdata(req_wdata), .wstrb(req_wstrb),
    .mir_set(mir_set), .mir_idx(per_idx), .mir_lanes(req_wstrb),
    .rd_idx(per_idx), .cur_lock(cur_lock), .rd_data(lock_rd)
  );

  rlk_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wbits(req_wdata[31:30]),
    .hard(hard), .ufb(ufb)
  );

  assign req_ready  = !rsp_valid || rsp_ready;
  assign acc        = req_valid && req_ready;
  assign blk_user   = req_user && ufb;
  assign wr_hit     = (region == RG_REG) || (region == RG_MIR);
  assign lane_clash = |(cur_lock & req_wstrb);
  assign frozen_hit = hard && ((region == RG_LOCK) || (region == RG_CFG));

  assign per_we    = acc && req_write && !blk_user && wr_hit && !lane_clash;
  assign per_wdata = req_wdata;
  assign per_wstrb = req_wstrb;
  assign mir_set   = per_we && (region == RG_MIR);
  assign lk_we     = acc && req_write && !blk_user && (region == RG_LOCK) && !hard;
  assign cfg_we    = acc && req_write && !blk_user && (region == RG_CFG);

  always_comb begin
    err_c = blk_user || (region == RG_NONE) ||
            (req_write && ((wr_hit && lane_clash) || frozen_hit));
    rd_c  = '0;
    if (!blk_user && !req_write) begin
      case (region)
        RG_REG, RG_MIR: rd_c = per_rdata;
        RG_LOCK:        rd_c = lock_rd;
        RG_CFG:         rd_c = {hard, ufb, 30'b0};
        default:        rd_c = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_c;
      rsp_err   <= err_c;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_we_accepted_r1: assert property (@(posedge clk) disable iff (!rst_n)
    per_we |-> (req_valid && req_ready && req_write));
  p_locked_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !blk_user && wr_hit && |(cur_lock & req_wstrb)) |=> (rsp_valid && rsp_err));
  p_user_bar_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_user && ufb) |=> (rsp_valid && rsp_err && rsp_rdata == 32'h0));
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
endmodule

// File: tb/reg_lock_guard_bench.sv
module reg_lock_guard_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          NREG       = 8;
  localparam int          RBW        = 'h80;
  localparam logic [7:0]  PROT       = 8'b1011_0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic        req_ready;
  logic [13:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_wstrb = '0;
  logic        rsp_valid, rsp_err;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        per_we;
  logic [2:0]  per_idx;
  logic [31:0] per_wdata, per_rdata;
  logic [3:0]  per_wstrb;

  logic [31:0] pmem [NREG];
  logic [31:0] m_reg [NREG];
  logic [3:0]  m_lk [NREG];
  bit          m_hard, m_ufb;
  int          checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_lock_guard u_reg_lock_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_user(req_user), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wstrb(req_wstrb), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .per_we(per_we), .per_idx(per_idx), .per_wdata(per_wdata),
    .per_wstrb(per_wstrb), .per_rdata(per_rdata)
  );

  assign per_rdata = pmem[per_idx];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) pmem[i] <= '0;
    end else if (per_we) begin
      for (int k = 0; k < 4; k++)
        if (per_wstrb[k]) pmem[per_idx][8*k +: 8] <= per_wdata[8*k +: 8];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic predict(input bit w, input bit u, input logic [13:0] a,
                         input logic [31:0] wd, input logic [3:0] ws,
                         output logic [31:0] rd, output bit er);
    int wa, rel, idx, lw;
    bit mir;
    wa = int'(a[13:2]);
    rd = '0;
    er = 1'b0;
    if (u && m_ufb) begin
      er = 1'b1;
    end else if (wa == 'hFFF) begin
      if (w) begin
        if (m_hard) er = 1'b1;
        else begin m_hard = wd[31]; m_ufb = wd[30]; end
      end else rd = {m_hard, m_ufb, 30'b0};
    end else if (wa >= 'hE00) begin
      lw = wa - 'hE00;
      for (int k = 0; k < 4; k++) begin
        idx = lw*4 + k - RBW;
        if (idx >= 0 && idx < NREG) begin
          if (!w) rd[8*k +: 4] = m_lk[idx];
          else if (!m_hard && ws[k] && PROT[idx])
            for (int j = 0; j < 4; j++) if (wd[8*k+4+j]) m_lk[idx][j] = wd[8*k+j];
        end
      end
      if (w && m_hard) er = 1'b1;
    end else begin
      mir = (wa >= 'h800);
      rel = mir ? wa - 'h800 : wa;
      idx = rel - RBW;
      if (idx < 0 || idx >= NREG) er = 1'b1;
      else if (!w) rd = m_reg[idx];
      else if ((m_lk[idx] & ws) != 0) er = 1'b1;
      else begin
        for (int k = 0; k < 4; k++) if (ws[k]) m_reg[idx][8*k +: 8] = wd[8*k +: 8];
        if (mir && PROT[idx] && !m_hard) m_lk[idx] = m_lk[idx] | ws;
      end
    end
  endtask

  task automatic access(input bit w, input bit u, input logic [13:0] a,
                        input logic [31:0] wd, input logic [3:0] ws, input string tag,
                        output logic [31:0] got);
    logic [31:0] erd;
    bit er;
    predict(w, u, a, wd, ws, erd, er);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_user = u;
    req_addr = a; req_wdata = wd; req_wstrb = ws;
    @(negedge clk);
    req_valid = 1'b0;
    got = rsp_rdata;
    check(rsp_valid == 1'b1, {tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check(rsp_rdata == erd, {tag, " rdata"}, rsp_rdata, erd);
    check(rsp_err == er, {tag, " err"}, 32'(rsp_err), 32'(er));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] g;
    logic [13:0] a;
    logic [31:0] d;
    bit w, u;
    void'($urandom(32'd20240917));
    for (int i = 0; i < NREG; i++) begin m_reg[i] = '0; m_lk[i] = '0; end
    m_hard = 1'b0; m_ufb = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(rsp_valid == 1'b0, "R12 rsp_valid", 32'(rsp_valid), 0);
    check(req_ready == 1'b1, "R12 req_ready", 32'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    access(0, 0, 14'h3FFC, 0, 0, "R12 cfg reset", g);
    access(0, 0, 14'h3880, 0, 0, "R12 locks reset", g);
    check(g == 32'h0, "R12 lock word zero", g, 0);
    // R1: plain write and read
    access(1, 0, 14'h0200, 32'hA5A5_A5A5, 4'hF, "R1 write", g);
    access(0, 0, 14'h0200, 0, 0, "R1 read", g);
    check(g == 32'hA5A5_A5A5, "R1 literal", g, 32'hA5A5_A5A5);
    // R2: mirror write locks lanes 0,1 of 0x200
    access(1, 0, 14'h2200, 32'h1122_3344, 4'b0011, "R2 mirror write", g);
    access(0, 0, 14'h3880, 0, 0, "R3 lock readback", g);
    check(g == 32'h0000_0003, "R3 literal lock", g, 32'h3);
    // R4: blocked and unblocked lanes
    access(1, 0, 14'h0200, 32'hFFFF_FFFF, 4'b0001, "R4 blocked", g);
    access(1, 0, 14'h2200, 32'hFFFF_FFFF, 4'b0010, "R4 blocked mirror", g);
    access(1, 0, 14'h0200, 32'h00CC_0000, 4'b0100, "R4 free lane", g);
    access(0, 0, 14'h0200, 0, 0, "R5 locked read", g);
    check(g == 32'hA5CC_3344, "R5 literal", g, 32'hA5CC_3344);
    // R3: write-enable gating
    access(1, 0, 14'h3880, 32'h0000_0001, 4'b0001, "R3 no enable", g);
    access(0, 0, 14'h3880, 0, 0, "R3 unchanged", g);
    access(1, 0, 14'h3880, 32'h0000_0010, 4'b0001, "R3 clear lane0", g);
    access(0, 0, 14'h3880, 0, 0, "R3 after clear", g);
    check(g == 32'h0000_0002, "R3 literal clear", g, 32'h2);
    access(1, 0, 14'h0200, 32'h0000_0077, 4'b0001, "R3 write after clear", g);
    // R9: non-protectable word at 0x20C (lane 3 of 0x3880)
    access(1, 0, 14'h3880, 32'hFF00_0000, 4'b1000, "R9 lock write", g);
    access(0, 0, 14'h3880, 0, 0, "R9 lock reads zero", g);
    access(1, 0, 14'h220C, 32'h1234_5678, 4'hF, "R9 mirror no lock", g);
    access(1, 0, 14'h020C, 32'h8765_4321, 4'hF, "R9 write after mirror", g);
    access(0, 0, 14'h020C, 0, 0, "R9 readback", g);
    // R10: unmapped
    access(0, 0, 14'h0100, 0, 0, "R10 unmapped", g);
    access(1, 0, 14'h2100, 32'h1, 4'hF, "R10 unmapped mirror", g);
    // R8: user bar
    access(1, 0, 14'h3FFC, 32'h4000_0000, 4'hF, "R6 set user bar", g);
    access(0, 0, 14'h3FFC, 0, 0, "R6 cfg read", g);
    access(0, 1, 14'h0204, 0, 0, "R8 user read", g);
    access(1, 1, 14'h0204, 32'hDEAD_BEEF, 4'hF, "R8 user write", g);
    access(0, 0, 14'h0204, 0, 0, "R8 unchanged", g);
    access(1, 0, 14'h3FFC, 32'h0, 4'hF, "R6 clear user bar", g);
    access(0, 1, 14'h0204, 0, 0, "R8 user allowed", g);
    // R11: back-pressure
    begin
      logic [31:0] erd, held;
      bit er;
      predict(0, 0, 14'h0200, 0, 0, erd, er);
      @(negedge clk);
      rsp_ready = 1'b0;
      req_valid = 1'b1; req_write = 1'b0; req_user = 1'b0; req_addr = 14'h0200;
      @(negedge clk);
      req_valid = 1'b0;
      held = rsp_rdata;
      check(rsp_valid && !req_ready, "R11 stalled", {30'b0, rsp_valid, req_ready}, 32'h2);
      check(held == erd, "R11 data", held, erd);
      @(negedge clk);
      check(rsp_valid && rsp_rdata == held, "R11 held", rsp_rdata, held);
      rsp_ready = 1'b1;
      @(negedge clk);
      check(!rsp_valid, "R11 drained", 32'(rsp_valid), 0);
    end
    // random mix
    for (int n = 0; n < 600; n++) begin
      int kind, r;
      kind = int'($urandom % 6);
      r = int'($urandom % NREG);
      w = $urandom % 2;
      u = ($urandom % 4) == 0;
      d = $urandom;
      case (kind)
        0, 5: a = 14'(32'h200 + 4*r);
        1: a = 14'(32'h2200 + 4*r);
        2: a = ($urandom % 2) ? 14'h3880 : 14'h3884;
        3: begin a = 14'h3FFC; d[31] = 1'b0; d[30] = ($urandom % 3) == 0; end
        default: a = ($urandom % 2) ? 14'h0040 : 14'h2500;
      endcase
      access(w, u, a, d, 4'($urandom), "R1 random", g);
    end
    access(1, 0, 14'h3FFC, 32'h0, 4'hF, "R6 clear", g);
    // R7: hard lock
    access(1, 0, 14'h3FFC, 32'h8000_0000, 4'hF, "R6 set hard", g);
    access(0, 0, 14'h3FFC, 0, 0, "R6 hard read", g);
    check(g == 32'h8000_0000, "R6 literal", g, 32'h8000_0000);
    access(1, 0, 14'h3FFC, 32'h4000_0000, 4'hF, "R7 cfg frozen", g);
    access(0, 0, 14'h3FFC, 0, 0, "R7 cfg still", g);
    access(1, 0, 14'h3884, 32'hF0F0_F0F0, 4'hF, "R7 lock frozen", g);
    access(0, 0, 14'h3884, 0, 0, "R7 locks unchanged", g);
    access(1, 0, 14'h3880, 32'h00F0_F0F0, 4'hF, "R7 lock frozen b", g);
    access(0, 0, 14'h3880, 0, 0, "R7 locks unchanged b", g);
    for (int i = 0; i < NREG; i++) begin
      access(1, 0, 14'(32'h2200 + 4*i), 32'h0F0F_0F0F, 4'b1000, "R7 mirror no lock", g);
      access(0, 0, 14'(32'h3880 + 4*(i/4)), 0, 0, "R7 lock after mirror", g);
    end
    // R1: peripheral contents match model
    for (int i = 0; i < NREG; i++)
      check(pmem[i] == m_reg[i], "R1 peripheral word", pmem[i], m_reg[i]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule